// File: doc/BRIEF.md
# Parallel Printer Port Host Register Front End

This block is the host-facing register layer of a bidirectional parallel printer port. The host reaches three registers through a two-bit select and active-low read and write strobes, all sampled in the block's clock domain. The three registers are a data register, an address-FIFO port and a status register. In the forward-only standard mode and in the bidirectional byte mode, a write to the data register is latched when the write strobe is released, and the latched byte drives the port's outgoing data. A read of the data register, or of the address-FIFO port, returns the live peripheral data lines.

Bytes written to the address-FIFO port go into a small tagged FIFO. Each entry holds a ninth tag bit, and this port always writes the tag as 0. When the FIFO is full, the write is dropped. A peripheral-side engine drains the FIFO through a show-ahead pop interface.

The status register is built from the peripheral handshake pins, two constant-one bits and a sticky timeout flag. The timeout flag belongs to the enhanced address/data transfer mode (EPP). A cycle counter watches each transfer that the peripheral engine starts. If the transfer runs past the timeout window, the counter aborts it and sets the flag.

Top module: `ppt_host_regs`

## Requirements
- R1: On the cycle after a rising edge of `wr_n` with `sel`=00, `data_out` takes `wdata`, but only when `mode` is 000 (standard) or 001 (bidirectional byte). In any other mode the write leaves `data_out` unchanged. `data_out` resets to 0.
- R2: When `sel` is 00 (data) or 10 (address-FIFO), `rdata` equals `pd_in`.
- R3: A rising edge of `wr_n` with `sel`=10 pushes `wdata` into the FIFO when `fifo_full` is 0. When `fifo_full` is 1, the byte is discarded and the FIFO contents and flags are unchanged.
- R4: Every entry pushed through the address-FIFO port leaves the FIFO with `pop_tag`=0.
- R5: The FIFO holds 16 entries in first-in first-out order. `fifo_full` is high at 16 entries and `fifo_empty` at 0. `pop_data`/`pop_tag` show the oldest entry, and `pop` removes it; `pop` has no effect while the FIFO is empty.
- R6: The status byte is {~busy, ack_n, pe, slct, err_n, 1, 1, bit0}, with bit 7 on the left.
- R7: Status bit 0 reads 1 whenever `mode` is not 100 (EPP).
- R8: In mode 100, `xfer_start` starts a counter of TICKS = CLK_HZ/1e6 × TIMEOUT_US cycles. If the counter expires, `xfer_abort` pulses for exactly one cycle, TICKS+1 cycles after the start cycle, and status bit 0 then reads 1 until it is cleared.
- R9: The timeout flag clears on a `wr_n` rising edge with `sel`=01 and `wdata[0]`=1, or when `mode` leaves 100. A write with `wdata[0]`=0 leaves it set.
- R10: The status byte is sampled on the cycle after `rd_n` falls with `sel`=01. `rdata` then holds that value while `rd_n` stays low, even if the pins change.
- R11: `xfer_done` before expiry stops the counter, so no abort and no flag result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Port mode: 000 standard, 001 byte bidir, 100 EPP, others FIFO modes |
| sel | input | 2 | Register select: 00 data, 01 status, 10 address-FIFO |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| data_out | output | 8 | Latched outgoing data byte |
| pd_in | input | 8 | Peripheral data lines |
| busy | input | 1 | Busy pin |
| ack_n | input | 1 | Acknowledge pin |
| pe | input | 1 | Paper-empty pin |
| slct | input | 1 | Select pin |
| err_n | input | 1 | Error pin |
| xfer_start | input | 1 | Peripheral engine starts an EPP transfer |
| xfer_done | input | 1 | Peripheral engine finished the transfer |
| xfer_abort | output | 1 | One-cycle timeout abort pulse |
| pop | input | 1 | Remove the oldest FIFO entry |
| pop_data | output | 8 | Oldest FIFO byte |
| pop_tag | output | 1 | Tag bit of the oldest entry |
| fifo_full | output | 1 | FIFO holds 16 entries |
| fifo_empty | output | 1 | FIFO holds no entry |

## Verification
Some properties are checked on every cycle:
- the full and empty flags are never both high;
- `data_out` changes only in the two latching modes;
- the abort pulse lasts one cycle and appears only in EPP mode;
- a write to a full FIFO changes nothing;
- the status byte holds during a read.

Other behaviour needs the bench's scenarios, because it depends on values or on long histories:
- the exact status bit layout;
- first-in first-out ordering against a model queue;
- the exact abort cycle;
- the two clearing paths of the sticky flag.

// File: rtl/ppt_host_pkg.sv
// Shared constants for the parallel port host register front end.
// Assumes a 3-bit mode code and a 2-bit register select.
package ppt_host_pkg;
    localparam logic [2:0] MODE_STD  = 3'b000;
    localparam logic [2:0] MODE_BYTE = 3'b001;
    localparam logic [2:0] MODE_EPP  = 3'b100;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'b00,
        SEL_STAT  = 2'b01,
        SEL_AFIFO = 2'b10,
        SEL_NONE  = 2'b11
    } sel_t;
endpackage

// File: rtl/ppt_host_fifo.sv
// Synchronous show-ahead FIFO for tagged bytes.
// Assumes push is dropped when full and pop is ignored when empty.
module ppt_host_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ppt_host_timer.sv
// Transfer timeout watchdog with sticky flag.
// Assumes start/done are single-cycle pulses from the peripheral engine.
module ppt_host_timer #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_US = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic done,
    input  logic clr,
    output logic abort,
    output logic flag
);
    localparam int unsigned TICKS = (CLK_HZ / 1_000_000) * TIMEOUT_US;
    localparam int          CW    = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;
    logic          running;
    logic          expire;

    assign expire = running && enable && (cnt == CW'(TICKS - 1));

    // Counter run control and tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (done || expire) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    // One-cycle abort pulse and sticky flag; a new expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort <= 1'b0;
            flag  <= 1'b0;
        end else begin
            abort <= expire && !start && !done;
            if (!enable)                       flag <= 1'b0;
            else if (expire && !start && !done) flag <= 1'b1;
            else if (clr)                      flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ppt_host_status.sv
// Builds the status byte from pins and holds a snapshot during a read.
// Assumes rd_fall is a one-cycle pulse on the read strobe's leading edge.
module ppt_host_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_fall,
    input  logic       epp_mode,
    input  logic       to_flag,
    input  logic       busy,
    input  logic       ack_n,
    input  logic       pe,
    input  logic       slct,
    input  logic       err_n,
    output logic [7:0] snap
);
    logic [7:0] live;

    // Live status byte assembly.
    always_comb begin
        live = {~busy, ack_n, pe, slct, err_n, 2'b11, epp_mode ? to_flag : 1'b1};
    end

    // Snapshot taken at the start of each status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= 8'hFF;
        else if (rd_fall) snap <= live;
    end
endmodule

// File: rtl/ppt_host_regs.sv
// Host register front end of a parallel printer port: register decode,
// data latch, tagged address FIFO, status snapshot and transfer timeout.
// Assumes the host strobes are already synchronous to clk.
module ppt_host_regs
    import ppt_host_pkg::*;
#(
    parameter int          FIFO_DEPTH = 16,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_US = 10_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic [1:0] sel,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] data_out,
    input  logic [7:0] pd_in,
    input  logic       busy,
    input  logic       ack_n,
    input  logic       pe,
    input  logic       slct,
    input  logic       err_n,
    input  logic       xfer_start,
    input  logic       xfer_done,
    output logic       xfer_abort,
    input  logic       pop,
    output logic [7:0] pop_data,
    output logic       pop_tag,
    output logic       fifo_full,
    output logic       fifo_empty
);
    logic       wr_q, rd_q;
    logic       wr_rise, rd_fall;
    logic       epp_mode, latch_mode;
    logic       to_flag, to_clr;
    logic       afifo_push;
    logic [8:0] head;
    logic [7:0] stat_snap;

    assign wr_rise    = wr_n && !wr_q;
    assign rd_fall    = !rd_n && rd_q && (sel == SEL_STAT);
    assign epp_mode   = (mode == MODE_EPP);
    assign latch_mode = (mode == MODE_STD) || (mode == MODE_BYTE);
    assign afifo_push = wr_rise && (sel == SEL_AFIFO);
    assign to_clr     = wr_rise && (sel == SEL_STAT) && wdata[0];

    // Strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    // Data register latch on write-strobe release.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        data_out <= '0;
        else if (wr_rise && sel == SEL_DATA && latch_mode) data_out <= wdata;
    end

    // Read data mux: status snapshot or live peripheral lines.
    always_comb begin
        rdata = (sel == SEL_STAT) ? stat_snap : pd_in;
    end

    ppt_host_fifo #(.DEPTH(FIFO_DEPTH), .W(9)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (afifo_push),
        .push_data ({1'b0, wdata}),
        .pop       (pop),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    assign pop_tag  = head[8];
    assign pop_data = head[7:0];

    ppt_host_timer #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (epp_mode),
        .start  (xfer_start),
        .done   (xfer_done),
        .clr    (to_clr),
        .abort  (xfer_abort),
        .flag   (to_flag)
    );

    ppt_host_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fall  (rd_fall),
        .epp_mode (epp_mode),
        .to_flag  (to_flag),
        .busy     (busy),
        .ack_n    (ack_n),
        .pe       (pe),
        .slct     (slct),
        .err_n    (err_n),
        .snap     (stat_snap)
    );
endmodule

// File: rtl/ppt_host_regs_chk.sv
// Property checker for ppt_host_regs, attached by bind.
// Assumes it sees only the top-level ports.
module ppt_host_regs_chk
    import ppt_host_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic [1:0] sel,
    input logic       wr_n,
    input logic       rd_n,
    input logic [7:0] rdata,
    input logic [7:0] data_out,
    input logic       xfer_abort,
    input logic       pop,
    input logic [7:0] pop_data,
    input logic       fifo_full,
    input logic       fifo_empty
);
    // R5: occupancy flags are exclusive.
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R1: the data latch moves only in the two latching modes.
    a_r1_latch_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> ($past(mode) == MODE_STD || $past(mode) == MODE_BYTE));

    // R3: a write into a full FIFO changes nothing.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) && sel == SEL_AFIFO && fifo_full && !pop) |=> (fifo_full && $stable(pop_data)));

    // R8: the abort is a single-cycle pulse.
    a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> !xfer_abort);

    // R8: an abort follows a cycle in EPP mode.
    a_r8_abort_in_epp: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> ($past(mode) == MODE_EPP));

    // R10: the status byte holds during a read.
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !$past(rd_n) && sel == SEL_STAT && $past(sel) == SEL_STAT
         && $past(rd_n, 2) == 1'b0) |-> $stable(rdata));
endmodule

bind ppt_host_regs ppt_host_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .sel        (sel),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .rdata      (rdata),
    .data_out   (data_out),
    .xfer_abort (xfer_abort),
    .pop        (pop),
    .pop_data   (pop_data),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/ppt_host_regs_tb.sv
module ppt_host_regs_tb_top;
    localparam int TICKS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [1:0] sel = 2'b11;
    logic       wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] wdata = '0, pd_in = '0;
    logic [7:0] rdata, data_out, pop_data;
    logic       busy = 0, ack_n = 1, pe = 0, slct = 0, err_n = 1;
    logic       xfer_start = 0, xfer_done = 0, pop = 0;
    logic       xfer_abort, pop_tag, fifo_full, fifo_empty;

    int total = 0, bad = 0, aborts = 0;
    logic [7:0] exp_data = '0;
    logic [8:0] mq[$];

    always #5 clk = ~clk;

    ppt_host_regs #(.FIFO_DEPTH(16), .CLK_HZ(2_000_000), .TIMEOUT_US(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .wr_n(wr_n), .rd_n(rd_n),
        .wdata(wdata), .rdata(rdata), .data_out(data_out), .pd_in(pd_in),
        .busy(busy), .ack_n(ack_n), .pe(pe), .slct(slct), .err_n(err_n),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_abort(xfer_abort),
        .pop(pop), .pop_data(pop_data), .pop_tag(pop_tag),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty));

    always @(negedge clk) if (rst_n && xfer_abort) aborts++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FIFO? no - FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_exp(input bit epp, input bit flg);
        return {~busy, ack_n, pe, slct, err_n, 2'b11, epp ? flg : 1'b1};
    endfunction

    task automatic host_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); sel = s; wdata = d; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk); sel = 2'b11;
    endtask

    // Status read; pins are disturbed mid-read to check R10.
    task automatic read_status(output logic [7:0] v);
        logic [7:0] first;
        @(negedge clk); sel = 2'b01; rd_n = 0;
        @(negedge clk); first = rdata;
        {busy, ack_n, pe, slct, err_n} = ~{busy, ack_n, pe, slct, err_n};
        @(negedge clk); chk(rdata == first, "R10", rdata, first);
        {busy, ack_n, pe, slct, err_n} = ~{busy, ack_n, pe, slct, err_n};
        rd_n = 1; v = first;
        @(negedge clk); sel = 2'b11;
    endtask

    task automatic do_pop();
        @(negedge clk);
        if (mq.size() > 0) begin
            chk(pop_data == mq[0][7:0], "R5", pop_data, mq[0][7:0]);
            chk(pop_tag == 1'b0, "R4", pop_tag, 0);
            void'(mq.pop_front());
        end
        pop = 1;
        @(negedge clk); pop = 0;
    endtask

    task automatic push(input logic [7:0] d);
        host_write(2'b10, d);
        if (mq.size() < 16) mq.push_back({1'b0, d});
    endtask

    task automatic flags_chk();
        chk(fifo_empty == (mq.size() == 0), "R5", fifo_empty, mq.size() == 0);
        chk(fifo_full == (mq.size() == 16), "R3", fifo_full, mq.size() == 16);
    endtask

    task automatic start_xfer();
        @(negedge clk); xfer_start = 1;
        @(negedge clk); xfer_start = 0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int a0;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(data_out == 8'h00, "R1 reset", data_out, 0);
        chk(fifo_empty && !fifo_full, "R5 reset", {fifo_full, fifo_empty}, 1);
        chk(!xfer_abort, "R8 reset", xfer_abort, 0);

        // R1: data latch across random modes.
        for (int i = 0; i < 24; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            mode = 3'($urandom_range(0, 5));
            host_write(2'b00, d);
            if (mode <= 3'b001) exp_data = d;
            chk(data_out == exp_data, "R1", data_out, exp_data);
        end

        // R2: live peripheral data on data and address-FIFO reads.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); pd_in = 8'($urandom); sel = (i % 2 == 0) ? 2'b00 : 2'b10;
            #1 chk(rdata == pd_in, "R2", rdata, pd_in);
        end

        // R3/R5: fill, overflow, drain.
        mode = 3'b011;
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
        flags_chk();
        push(8'hEE);
        flags_chk();
        chk(pop_data == mq[0][7:0], "R3 drop", pop_data, mq[0][7:0]);
        while (mq.size() > 0) do_pop();
        flags_chk();
        do_pop();
        flags_chk();
        // R4/R5: random push/pop mix against the model queue.
        for (int i = 0; i < 120; i++) begin
            if ($urandom_range(0, 2) != 0) push(8'($urandom));
            else do_pop();
            flags_chk();
        end
        while (mq.size() > 0) do_pop();

        // R6/R7: status layout outside EPP mode.
        for (int i = 0; i < 10; i++) begin
            mode = (i % 2 == 0) ? 3'b000 : 3'b101;
            {busy, ack_n, pe, slct, err_n} = 5'($urandom);
            read_status(v);
            chk(v == stat_exp(0, 0), "R6 R7", v, stat_exp(0, 0));
        end

        // R8: timeout in EPP mode.
        mode = 3'b100;
        read_status(v);
        chk(v[0] == 1'b0, "R8 idle", v[0], 0);
        a0 = aborts;
        @(negedge clk); xfer_start = 1;
        @(negedge clk); xfer_start = 0;
        repeat (TICKS - 1) @(negedge clk);
        chk(!xfer_abort, "R8 early", xfer_abort, 0);
        @(negedge clk);
        chk(xfer_abort, "R8 edge", xfer_abort, 1);
        @(negedge clk);
        chk(aborts == a0 + 1, "R8 pulse", aborts - a0, 1);
        read_status(v);
        chk(v == stat_exp(1, 1), "R8 flag", v, stat_exp(1, 1));

        // R9: clear rules.
        host_write(2'b01, 8'hFE);
        read_status(v);
        chk(v[0] == 1'b1, "R9 w0", v[0], 1);
        host_write(2'b01, 8'h01);
        read_status(v);
        chk(v[0] == 1'b0, "R9 w1c", v[0], 0);
        start_xfer();
        repeat (TICKS + 2) @(negedge clk);
        read_status(v);
        chk(v[0] == 1'b1, "R9 reset", v[0], 1);
        mode = 3'b000;
        repeat (2) @(negedge clk);
        mode = 3'b100;
        read_status(v);
        chk(v[0] == 1'b0, "R9 exit", v[0], 0);

        // R11: completed transfer never aborts.
        a0 = aborts;
        start_xfer();
        repeat (5) @(negedge clk);
        xfer_done = 1;
        @(negedge clk); xfer_done = 0;
        repeat (TICKS + 5) @(negedge clk);
        chk(aborts == a0, "R11", aborts - a0, 0);
        read_status(v);
        chk(v[0] == 1'b0, "R11 flag", v[0], 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule